// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire PHY management bus: a clock line (MDC) and a shared bidirectional data line (MDIO). A client issues one request at a time. Each request carries a read-or-write flag, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block then builds the whole management frame on the wire. When the frame is over it raises a one-cycle completion strobe. For a read it also returns the 16-bit result and an error flag.

The MDIO line is split into three signals: an output value, an output enable and an input. A tristate pad outside the block joins them. The MDC speed comes from a divider value that the block captures when it accepts a request. On a read the PHY must pull the turnaround bit low. If it does not, the block clocks a recovery burst with the line released and reports an error instead of data.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 MDC cycles during which the block drives MDIO (`mdio_oe`=1) with the value 1.
- R2: After the preamble the block drives 14 bits, MSB first, one per MDC cycle: start bits 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the 5-bit PHY address, then the 5-bit register address.
- R3: `mdio_o` and `mdio_oe` change only while `mdc` is low. They are held through every cycle in which `mdc` is high, so the PHY samples stable data on the rising edge.
- R4: On a write the block drives the turnaround bits 1 then 0, then the 16 data bits MSB first. It then releases MDIO for one more MDC cycle, for 65 MDC cycles in total.
- R5: On a read the block releases MDIO from MDC cycle 47 (the first turnaround cycle) to the end of the frame. If the PHY returns 0 in that turnaround cycle, the block samples 16 data bits MSB first at the end of the high half of cycles 48 to 63. Cycle 64 is a single released idle cycle, for 64 MDC cycles in total. `rdata` holds the result from the completion strobe onward.
- R6: On a read where MDIO is 1 at the end of the high half of the turnaround cycle, the block clocks 32 more cycles with MDIO released, for 79 in total. It then completes with `err`=1 and `rdata`=0.
- R7: Each MDC half-period, high or low, lasts (`div_i`+1) clock cycles. The value used is the one on `div_i` in the accepting cycle; later changes have no effect on the running frame.
- R8: `busy` rises in the cycle after acceptance and stays high until the completion cycle. In that cycle `done` is 1 and `busy` is 0, and `done` lasts exactly one cycle.
- R9: A request is accepted only while `busy` is 0. A `req_valid` pulse during a frame leaves the running frame unchanged and starts no new frame.
- R10: While `busy` is 0, `mdc` is low and MDIO is released. `err` is 0 after any frame that is not a failed read, and `rdata` is 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| div_i | input | DIV_W | MDC half-period minus one, in clock cycles |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Turnaround failure on the last read |
| rdata | output | 16 | Read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check the cycle-level rules on every cycle. These are the data line staying stable while MDC is high, the length of every MDC half-period against the captured divider, the quiet bus while idle, the single-cycle completion strobe ending `busy`, and an error appearing only with completion. The frame content is shown only by the bench's scenarios, which record MDIO at each rising MDC edge and check it against frames built from the request. That covers the preamble, header order, opcodes, turnaround handling, data order and cycle totals, together with read data, the recovery burst and the rejection of requests during a frame.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_TA,
        PH_RDAT,
        PH_WDAT,
        PH_TAIL,
        PH_RECOV
    } phase_e;

    localparam int PRE_CYC   = 32;
    localparam int HDR_BITS  = 14;
    localparam int DATA_BITS = 16;
    localparam int WR_BITS   = DATA_BITS + 2;
    localparam int RECOV_CYC = 32;
    localparam int CNT_W     = 6;

endpackage

// File: rtl/mdio_halfper_timer.sv
module mdio_halfper_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic             run,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] reload;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick = run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt    = load_val;
            tmr_d.reload = load_val;
        end else if (run) begin
            if (tmr_q.cnt == '0) tmr_d.cnt = tmr_q.reload;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear)         sh_d = '0;
        else if (shift_en) sh_d = {sh_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign data = sh_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [4:0]       req_phy,
    input  logic [4:0]       req_reg,
    input  logic [15:0]      req_wdata,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [15:0]      rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int TX_W = WR_BITS;

    typedef struct packed {
        phase_e                phase;
        logic                  half;
        logic [CNT_W-1:0]      cnt;
        logic [TX_W-1:0]       tx;
        logic                  wr;
        logic [DATA_BITS-1:0]  wdat;
        logic                  mdc;
        logic                  mdo;
        logic                  mdoe;
        logic                  busy;
        logic                  done;
        logic                  err;
        logic [DATA_BITS-1:0]  rdata;
    } st_t;

    st_t st_d, st_q;

    logic                 accept;
    logic                 tick;
    logic                 rx_clear;
    logic                 rx_shift;
    logic [DATA_BITS-1:0] rx_data;
    logic                 seg_end;
    logic [CNT_W-1:0]     seg_last;

    assign accept = (st_q.phase == PH_IDLE) && req_valid;

    mdio_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (div_i),
        .run      (st_q.busy),
        .tick     (tick)
    );

    mdio_rx_shift #(.W(DATA_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .shift_en (rx_shift),
        .bit_in   (mdio_i),
        .data     (rx_data)
    );

    always_comb begin
        case (st_q.phase)
            PH_PRE:   seg_last = CNT_W'(PRE_CYC - 1);
            PH_HDR:   seg_last = CNT_W'(HDR_BITS - 1);
            PH_RDAT:  seg_last = CNT_W'(DATA_BITS - 1);
            PH_WDAT:  seg_last = CNT_W'(WR_BITS - 1);
            PH_RECOV: seg_last = CNT_W'(RECOV_CYC - 1);
            default:  seg_last = '0;
        endcase
    end

    assign seg_end = (st_q.cnt == seg_last);

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        rx_clear = 1'b0;
        rx_shift = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (req_valid) begin
                st_d.phase = PH_PRE;
                st_d.half  = 1'b0;
                st_d.cnt   = '0;
                st_d.wr    = req_write;
                st_d.wdat  = req_wdata;
                st_d.tx    = {2'b01, (req_write ? 2'b01 : 2'b10), req_phy, req_reg,
                              {(TX_W - HDR_BITS){1'b0}}};
                st_d.mdc   = 1'b0;
                st_d.mdo   = 1'b1;
                st_d.mdoe  = 1'b1;
                st_d.busy  = 1'b1;
                st_d.err   = 1'b0;
                st_d.rdata = '0;
                rx_clear   = 1'b1;
            end
        end else if (tick) begin
            if (!st_q.half) begin
                st_d.mdc  = 1'b1;
                st_d.half = 1'b1;
            end else begin
                st_d.mdc  = 1'b0;
                st_d.half = 1'b0;
                st_d.cnt  = seg_end ? '0 : st_q.cnt + 1'b1;
                case (st_q.phase)
                    PH_PRE: begin
                        if (seg_end) begin
                            st_d.phase = PH_HDR;
                            st_d.mdo   = st_q.tx[TX_W-1];
                        end
                    end
                    PH_HDR: begin
                        st_d.tx = st_q.tx << 1;
                        if (seg_end) begin
                            if (st_q.wr) begin
                                st_d.phase = PH_WDAT;
                                st_d.tx    = {2'b10, st_q.wdat};
                                st_d.mdo   = 1'b1;
                            end else begin
                                st_d.phase = PH_TA;
                                st_d.mdo   = 1'b0;
                                st_d.mdoe  = 1'b0;
                            end
                        end else begin
                            st_d.mdo = st_q.tx[TX_W-2];
                        end
                    end
                    PH_TA: begin
                        st_d.phase = mdio_i ? PH_RECOV : PH_RDAT;
                    end
                    PH_RDAT: begin
                        rx_shift = 1'b1;
                        if (seg_end) st_d.phase = PH_TAIL;
                    end
                    PH_WDAT: begin
                        st_d.tx = st_q.tx << 1;
                        if (seg_end) begin
                            st_d.phase = PH_TAIL;
                            st_d.mdo   = 1'b0;
                            st_d.mdoe  = 1'b0;
                        end else begin
                            st_d.mdo = st_q.tx[TX_W-2];
                        end
                    end
                    PH_TAIL: begin
                        st_d.phase = PH_IDLE;
                        st_d.busy  = 1'b0;
                        st_d.done  = 1'b1;
                        st_d.err   = 1'b0;
                        st_d.rdata = st_q.wr ? '0 : rx_data;
                    end
                    PH_RECOV: begin
                        if (seg_end) begin
                            st_d.phase = PH_IDLE;
                            st_d.busy  = 1'b0;
                            st_d.done  = 1'b1;
                            st_d.err   = 1'b1;
                            st_d.rdata = '0;
                        end
                    end
                    default: st_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign err     = st_q.err;
    assign rdata   = st_q.rdata;
    assign mdc     = st_q.mdc;
    assign mdio_o  = st_q.mdo;
    assign mdio_oe = st_q.mdoe;
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [DIV_W-1:0] div_i,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);
    logic             mdc_prev_q;
    logic [DIV_W:0]   run_q;
    logic [DIV_W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev_q <= 1'b0;
            run_q      <= '0;
            cap_q      <= '0;
        end else begin
            mdc_prev_q <= mdc;
            if (req_valid && !busy) begin
                cap_q <= div_i;
                run_q <= '0;
            end else if (mdc != mdc_prev_q) begin
                run_q <= {{DIV_W{1'b0}}, 1'b1};
            end else if (run_q != {(DIV_W+1){1'b1}}) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assert_mdio_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mdc != mdc_prev_q) && (busy || done)) |-> (run_q == ({1'b0, cap_q} + 1'b1)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    assert_err_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);
endmodule

bind mdio_master mdio_master_checker #(.DIV_W(DIV_W)) u_mdio_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .div_i     (div_i),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [4:0]       req_phy = '0;
    logic [4:0]       req_reg = '0;
    logic [15:0]      req_wdata = '0;
    logic [DIV_W-1:0] div_i = '0;
    logic             busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0]      rdata;
    logic             mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    int   edge_n = 0;
    int   hi_cnt = 0;
    logic rec_o  [0:127];
    logic rec_oe [0:127];
    logic        phy_good = 1'b0;
    logic [15:0] phy_data = '0;

    logic        got_err;
    logic [15:0] got_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.DIV_W(DIV_W)) u_mdio_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata), .div_i(div_i),
        .busy(busy), .done(done), .err(err), .rdata(rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records the master's bit per rising MDC edge and answers reads
    always @(posedge mdc) begin
        edge_n = edge_n + 1;
        if (edge_n < 128) begin
            rec_o[edge_n]  = mdio_o;
            rec_oe[edge_n] = mdio_oe;
        end
        if (phy_good && edge_n == 47)                      mdio_i = 1'b0;
        else if (phy_good && edge_n >= 48 && edge_n <= 63) mdio_i = phy_data[63 - edge_n];
        else                                               mdio_i = 1'b1;
    end

    always @(negedge clk) if (mdc) hi_cnt = hi_cnt + 1;

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic run_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [DIV_W-1:0] dv,
                             input logic poke);
        int cyc;
        edge_n = 0;
        hi_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg;
        req_wdata = wd; div_i = dv;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R8 busy after accept", busy, 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 20) begin
                req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg;
                req_wdata = ~wd; div_i = dv + 8'd5;
            end else if (poke && cyc == 21) begin
                req_valid = 1'b0;
            end
        end
        chk(done === 1'b1, "R8 done reached", done, 1);
        chk(busy === 1'b0, "R8 busy low at done", busy, 0);
        got_err   = err;
        got_rdata = rdata;
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", done, 0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R10 idle bus", {mdc, mdio_oe}, 0);
    endtask

    task automatic chk_head(input logic wr, input logic [4:0] phy, input logic [4:0] rg);
        logic [13:0] hdr;
        int bad;
        bad = 0;
        for (int i = 1; i <= 32; i++) if (rec_o[i] !== 1'b1 || rec_oe[i] !== 1'b1) bad++;
        chk(bad == 0, "R1 preamble", bad, 0);
        hdr = {2'b01, (wr ? 2'b01 : 2'b10), phy, rg};
        bad = 0;
        for (int i = 0; i < 14; i++)
            if (rec_o[33+i] !== hdr[13-i] || rec_oe[33+i] !== 1'b1) bad++;
        chk(bad == 0, "R2 header bits", bad, 0);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [DIV_W-1:0] dv,
                           input logic poke);
        int bad;
        phy_good = 1'b0;
        run_frame(1'b1, phy, rg, wd, dv, poke);
        chk_head(1'b1, phy, rg);
        chk(rec_o[47] === 1'b1 && rec_o[48] === 1'b0 && rec_oe[47] === 1'b1 && rec_oe[48] === 1'b1,
            "R4 write turnaround", {rec_o[47], rec_o[48]}, 2);
        bad = 0;
        for (int i = 0; i < 16; i++)
            if (rec_o[49+i] !== wd[15-i] || rec_oe[49+i] !== 1'b1) bad++;
        chk(bad == 0, "R4 write data", bad, 0);
        chk(rec_oe[65] === 1'b0, "R4 release after data", rec_oe[65], 0);
        chk(edge_n == 65, "R4 write cycle count", edge_n, 65);
        chk(hi_cnt == 65 * (int'(dv) + 1), "R7 high time", hi_cnt, 65 * (int'(dv) + 1));
        chk(got_err === 1'b0 && got_rdata === 16'h0, "R10 write status", {got_err, got_rdata}, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(busy === 1'b0 && edge_n == 65, "R9 no frame from busy request", edge_n, 65);
        end
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] pd, input logic [DIV_W-1:0] dv);
        int bad;
        phy_good = 1'b1;
        phy_data = pd;
        run_frame(1'b0, phy, rg, 16'h0, dv, 1'b0);
        phy_good = 1'b0;
        chk_head(1'b0, phy, rg);
        bad = 0;
        for (int i = 47; i <= 64; i++) if (rec_oe[i] !== 1'b0) bad++;
        chk(bad == 0, "R5 read released", bad, 0);
        chk(edge_n == 64, "R5 read cycle count", edge_n, 64);
        chk(got_rdata === pd, "R5 read data", got_rdata, pd);
        chk(got_err === 1'b0, "R10 read no error", got_err, 0);
        chk(hi_cnt == 64 * (int'(dv) + 1), "R7 high time", hi_cnt, 64 * (int'(dv) + 1));
    endtask

    task automatic t_ta_fail(input logic [DIV_W-1:0] dv);
        int bad;
        phy_good = 1'b0;
        run_frame(1'b0, 5'h0A, 5'h15, 16'h0, dv, 1'b0);
        chk_head(1'b0, 5'h0A, 5'h15);
        chk(edge_n == 79, "R6 recovery cycle count", edge_n, 79);
        bad = 0;
        for (int i = 47; i <= 79; i++) if (rec_oe[i] !== 1'b0) bad++;
        chk(bad == 0, "R6 released during recovery", bad, 0);
        chk(got_err === 1'b1, "R6 error flag", got_err, 1);
        chk(got_rdata === 16'h0, "R6 no data", got_rdata, 0);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R8 reset status",
            {busy, done, err}, 0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R10 reset bus", {mdc, mdio_oe}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(5'h1B, 5'h04, 16'hA53C, 8'd1, 1'b0);
        t_read(5'h01, 5'h1F, 16'h8001, 8'd0);
        t_read(5'h12, 5'h09, 16'h3CA5, 8'd2);
        t_ta_fail(8'd1);
        t_write(5'h05, 5'h10, 16'h0FF1, 8'd3, 1'b1);
        t_read(5'h1F, 5'h00, 16'hFFFE, 8'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule